// File: doc/BRIEF.md
# Eight-bit accumulator ALU with status flags

This block is the arithmetic and logic stage of a small eight-bit processor core. Each clock it takes an operation code, an eight-bit operand, the present accumulator value and the present flag byte. One clock edge later it presents the new accumulator value and the new flag byte on registered outputs. The surrounding core feeds those outputs back into its own accumulator and flag storage.

The flag byte holds five live flags: sign, zero, parity, auxiliary (nibble) carry and carry. The other three bits are constants. The operation set covers the following:
- binary add and subtract, with or without the incoming carry;
- increment and decrement by one;
- bitwise AND, OR, XOR and invert;
- a compare that only sets flags;
- two circular rotates and two rotates through the carry;
- a packed-BCD decimal correction;
- set carry and invert carry.

Each operation has its own rule for which flags it writes. A flag that an operation does not write passes through from the input unchanged.

Top module: `acc_alu8`

## Requirements
- R1: While rst_n is low, accOut reads 0x00 and flagsOut reads 0x02.
- R2: Results appear one clock edge after their inputs are sampled. The flag byte has sign at bit 7, zero at bit 6, auxiliary carry at bit 4, parity at bit 2 and carry at bit 0. Bits 5 and 3 always read 0, and bit 1 always reads 1, whatever flagsIn holds.
- R3: Add (code 0) gives accIn+operand. Add-with-carry (code 1) adds the incoming carry as well. Carry is the carry out of bit 7, and auxiliary carry is the carry out of bit 3.
- R4: Subtract (code 2) gives accIn-operand. Subtract-with-borrow (code 3) also subtracts the incoming carry. Carry is set when a borrow leaves bit 7, and auxiliary carry is set when a borrow leaves the low nibble.
- R5: Compare (code 10) sets all five flags exactly as subtract would, and leaves the accumulator equal to accIn.
- R6: Increment (code 4) and decrement (code 5) change the accumulator by one. Carry is unchanged. Auxiliary carry shows a carry out of the low nibble (increment) or a borrow from it (decrement).
- R7: AND (code 6) clears carry and sets auxiliary carry. OR (code 7) and XOR (code 8) clear both.
- R8: Invert (code 9) gives the bitwise complement of accIn and leaves every flag unchanged.
- R9: Circular left rotate (code 11) copies bit 7 into both bit 0 and carry. Circular right rotate (code 12) copies bit 0 into both bit 7 and carry. Only the carry flag changes.
- R10: Left rotate through carry (code 13) moves the old carry into bit 0 and bit 7 into carry. Right rotate through carry (code 14) moves the old carry into bit 7 and bit 0 into carry. Only the carry flag changes.
- R11: Decimal adjust (code 15) works in two steps. It first adds 0x06 when the low nibble is above 9 or auxiliary carry is set. It then adds 0x60 when the high part of that intermediate value is above 9 (a carry out of bit 7 counts) or carry is set. The new carry is set exactly when the second step happens. Auxiliary carry is the carry out of bit 3 from the first step.
- R12: Set carry (code 16) forces carry to 1, and invert carry (code 17) inverts it. No other flag and not the accumulator changes.
- R13: For arithmetic, logic, compare and decimal-adjust operations, sign is bit 7 of the result, zero is set when the result is 0, and parity is set when the result has an even number of one bits.
- R14: Codes 18 to 31 pass accIn and the live flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opCode | input | 5 | Operation select |
| operand | input | 8 | Second operand |
| accIn | input | 8 | Present accumulator value |
| flagsIn | input | 8 | Present flag byte |
| accOut | output | 8 | Registered new accumulator value |
| flagsOut | output | 8 | Registered new flag byte |

## Verification
The adder is tried at its boundary cases:
- sums that wrap exactly to zero, which separates the zero flag from carry;
- nibble-crossing values such as 0x0F+1, which separate auxiliary carry from carry;
- subtractions with the incoming borrow set and clear, which show whether the carry is folded in only for the with-carry codes.

Rotates are run with the carry opposite to the bit being shifted out, so the circular and through-carry forms cannot be mistaken for each other. Decimal adjust is driven with values that need no correction, only the low step, only the high step, and a low step that spills into the high step. The bench also sweeps every code with mixed operands and flag bytes that have the constant bits set wrongly, which exposes flags leaking through from the wrong source.

// File: rtl/acc_alu8_pkg.sv
package acc_alu8_pkg;

  localparam int ACC_W = 8;
  localparam int NIB_W = 4;
  localparam int OP_W  = 5;

  localparam int FL_CY = 0;
  localparam int FL_P  = 2;
  localparam int FL_AC = 4;
  localparam int FL_Z  = 6;
  localparam int FL_S  = 7;

  localparam logic [ACC_W-1:0] FLAG_ONES = 8'h02;
  localparam logic [ACC_W-1:0] FLAG_LIVE = 8'hD5;
  localparam logic [NIB_W-1:0] BCD_MAX   = 4'd9;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_INC = 5'd4,  OP_DEC = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7,
    OP_XOR = 5'd8,  OP_CPL = 5'd9,  OP_CMP = 5'd10, OP_RLC = 5'd11,
    OP_RRC = 5'd12, OP_RAL = 5'd13, OP_RAR = 5'd14, OP_DAA = 5'd15,
    OP_STC = 5'd16, OP_CMC = 5'd17
  } aluOp_e;

  typedef enum logic [2:0] {
    U_ADDER, U_AND, U_OR, U_XOR, U_NOT, U_ROT, U_DAA, U_NONE
  } unit_e;

  typedef struct packed {
    unit_e unit;
    logic  subtract;
    logic  useCarry;
    logic  unitOperand;
    logic  keepAcc;
    logic  wrSzp;
    logic  wrCy;
    logic  wrAc;
    logic  rotLeft;
    logic  rotThrough;
    logic  cyToggle;
  } strobe_t;

endpackage

// File: rtl/acc_alu8_ctrl.sv
module acc_alu8_ctrl
  import acc_alu8_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output strobe_t         stb
);

  always_comb begin
    stb = '{unit: U_NONE, default: 1'b0};
    case (opCode)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
        stb.unit     = U_ADDER;
        stb.subtract = (opCode == OP_SUB) || (opCode == OP_SBB) || (opCode == OP_CMP);
        stb.useCarry = (opCode == OP_ADC) || (opCode == OP_SBB);
        stb.keepAcc  = (opCode == OP_CMP);
        stb.wrSzp    = 1'b1;
        stb.wrCy     = 1'b1;
        stb.wrAc     = 1'b1;
      end
      OP_INC, OP_DEC: begin
        stb.unit        = U_ADDER;
        stb.subtract    = (opCode == OP_DEC);
        stb.unitOperand = 1'b1;
        stb.wrSzp       = 1'b1;
        stb.wrAc        = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        stb.unit  = (opCode == OP_AND) ? U_AND : (opCode == OP_OR) ? U_OR : U_XOR;
        stb.wrSzp = 1'b1;
        stb.wrCy  = 1'b1;
        stb.wrAc  = 1'b1;
      end
      OP_CPL: stb.unit = U_NOT;
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        stb.unit       = U_ROT;
        stb.rotLeft    = (opCode == OP_RLC) || (opCode == OP_RAL);
        stb.rotThrough = (opCode == OP_RAL) || (opCode == OP_RAR);
        stb.wrCy       = 1'b1;
      end
      OP_DAA: begin
        stb.unit  = U_DAA;
        stb.wrSzp = 1'b1;
        stb.wrCy  = 1'b1;
        stb.wrAc  = 1'b1;
      end
      OP_STC, OP_CMC: begin
        stb.wrCy     = 1'b1;
        stb.cyToggle = (opCode == OP_CMC);
      end
      default: stb.keepAcc = 1'b1;
    endcase
  end

endmodule

// File: rtl/acc_alu8_datapath.sv
module acc_alu8_datapath
  import acc_alu8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          stb,
  input  logic [ACC_W-1:0] accIn,
  input  logic [ACC_W-1:0] operand,
  input  logic [ACC_W-1:0] flagsIn,
  output logic [ACC_W-1:0] accQ,
  output logic [ACC_W-1:0] flagsQ
);

  logic             cyIn, acIn, cin;
  logic [ACC_W-1:0] opB;
  logic [ACC_W:0]   wide;
  logic [NIB_W:0]   nib;
  logic             loAdj, hiAdj;
  logic [ACC_W:0]   daaLo;
  logic [NIB_W:0]   daaNib;
  logic [ACC_W-1:0] daaRes, rotRes, result, nextAcc, nextFlags;
  logic             rotCy, newCy, newAc;

  assign cyIn = flagsIn[FL_CY];
  assign acIn = flagsIn[FL_AC];
  assign cin  = stb.useCarry & cyIn;
  assign opB  = stb.unitOperand ? ACC_W'(1) : operand;

  // shared adder: subtraction yields borrow in the top bits
  always_comb begin
    if (stb.subtract) begin
      wide = {1'b0, accIn} - {1'b0, opB} - (ACC_W+1)'(cin);
      nib  = {1'b0, accIn[NIB_W-1:0]} - {1'b0, opB[NIB_W-1:0]} - (NIB_W+1)'(cin);
    end else begin
      wide = {1'b0, accIn} + {1'b0, opB} + (ACC_W+1)'(cin);
      nib  = {1'b0, accIn[NIB_W-1:0]} + {1'b0, opB[NIB_W-1:0]} + (NIB_W+1)'(cin);
    end
  end

  // two-step BCD correction
  always_comb begin
    loAdj  = (accIn[NIB_W-1:0] > BCD_MAX) | acIn;
    daaNib = {1'b0, accIn[NIB_W-1:0]} + (loAdj ? (NIB_W+1)'(6) : '0);
    daaLo  = {1'b0, accIn} + (loAdj ? (ACC_W+1)'(6) : '0);
    hiAdj  = daaLo[ACC_W] | cyIn | (daaLo[ACC_W-1:NIB_W] > BCD_MAX);
    daaRes = daaLo[ACC_W-1:0] + (hiAdj ? ACC_W'(8'h60) : '0);
  end

  always_comb begin
    if (stb.rotLeft) begin
      rotRes = {accIn[ACC_W-2:0], stb.rotThrough ? cyIn : accIn[ACC_W-1]};
      rotCy  = accIn[ACC_W-1];
    end else begin
      rotRes = {stb.rotThrough ? cyIn : accIn[0], accIn[ACC_W-1:1]};
      rotCy  = accIn[0];
    end
  end

  always_comb begin
    result = accIn;
    newCy  = cyIn;
    newAc  = acIn;
    case (stb.unit)
      U_ADDER: begin result = wide[ACC_W-1:0]; newCy = wide[ACC_W]; newAc = nib[NIB_W]; end
      U_AND:   begin result = accIn & operand; newCy = 1'b0; newAc = 1'b1; end
      U_OR:    begin result = accIn | operand; newCy = 1'b0; newAc = 1'b0; end
      U_XOR:   begin result = accIn ^ operand; newCy = 1'b0; newAc = 1'b0; end
      U_NOT:   result = ~accIn;
      U_ROT:   begin result = rotRes; newCy = rotCy; end
      U_DAA:   begin result = daaRes; newCy = hiAdj; newAc = daaNib[NIB_W]; end
      default: newCy = stb.cyToggle ? ~cyIn : 1'b1;
    endcase
  end

  always_comb begin
    nextAcc          = stb.keepAcc ? accIn : result;
    nextFlags        = (flagsIn & FLAG_LIVE) | FLAG_ONES;
    if (stb.wrSzp) begin
      nextFlags[FL_S] = result[ACC_W-1];
      nextFlags[FL_Z] = (result == '0);
      nextFlags[FL_P] = ~^result;
    end
    if (stb.wrAc) nextFlags[FL_AC] = newAc;
    if (stb.wrCy) nextFlags[FL_CY] = newCy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accQ   <= '0;
      flagsQ <= FLAG_ONES;
    end else begin
      accQ   <= nextAcc;
      flagsQ <= nextFlags;
    end
  end

  // R5: compare leaves the accumulator as it was presented
  a_r5_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(stb.keepAcc)) |-> accQ == $past(accIn));

  // R6 R8: operations without a carry write leave carry alone
  a_r6_carry_held: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(stb.wrCy)) |-> flagsQ[FL_CY] == $past(flagsIn[FL_CY]));

  // R8: invert touches no flag beyond the fixed bits
  a_r8_not_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(stb.unit == U_NOT)) |-> flagsQ == (($past(flagsIn) & FLAG_LIVE) | FLAG_ONES));

  // R9: circular left rotate wraps bit 7 into bit 0 and carry
  a_r9_rlc: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(stb.unit == U_ROT && stb.rotLeft && !stb.rotThrough))
      |-> (accQ[0] == $past(accIn[ACC_W-1]) && flagsQ[FL_CY] == $past(accIn[ACC_W-1])));

  // R13: zero and parity track the written accumulator
  a_r13_zero_parity: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(stb.wrSzp && !stb.keepAcc))
      |-> (flagsQ[FL_Z] == (accQ == '0) && flagsQ[FL_P] == ~^accQ));

  // R2: constant bits of the flag byte
  a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (flagsQ & ~FLAG_LIVE) == FLAG_ONES);

endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
  import acc_alu8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  opCode,
  input  logic [ACC_W-1:0] operand,
  input  logic [ACC_W-1:0] accIn,
  input  logic [ACC_W-1:0] flagsIn,
  output logic [ACC_W-1:0] accOut,
  output logic [ACC_W-1:0] flagsOut
);

  strobe_t stb;

  acc_alu8_ctrl u_ctrl (
    .opCode (opCode),
    .stb    (stb)
  );

  acc_alu8_datapath u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .accIn   (accIn),
    .operand (operand),
    .flagsIn (flagsIn),
    .accQ    (accOut),
    .flagsQ  (flagsOut)
  );

endmodule

// File: tb/acc_alu8_bench.sv
module acc_alu8_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] opCode = 5'd20;
  logic [7:0] operand = '0, accIn = '0, flagsIn = '0;
  logic [7:0] accOut, flagsOut;

  int checkCnt = 0;
  int failCnt  = 0;
  int cycleCnt = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] acc;
    logic [7:0] flg;
    string      tag;
    int         due;
  } exp_t;

  exp_t expQ[$];

  acc_alu8 u_acc_alu8 (
    .clk(clk), .rst_n(rst_n), .opCode(opCode), .operand(operand),
    .accIn(accIn), .flagsIn(flagsIn), .accOut(accOut), .flagsOut(flagsOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  function automatic string tagOf(input logic [4:0] op);
    case (op)
      0, 1:           return "R3";
      2, 3:           return "R4";
      10:             return "R5";
      4, 5:           return "R6";
      6, 7, 8:        return "R7";
      9:              return "R8";
      11, 12:         return "R9";
      13, 14:         return "R10";
      15:             return "R11";
      16, 17:         return "R12";
      default:        return "R14";
    endcase
  endfunction

  // independent model built from the requirement text
  function automatic logic [15:0] model(input logic [4:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic [7:0] f);
    int ia, ib, c, v;
    logic cy, ac, nc, na, szp, keep, lo;
    logic [7:0] r, fo;
    ia = int'(a); ib = int'(b);
    cy = f[0]; ac = f[4]; nc = cy; na = ac; szp = 1'b0; keep = 1'b0; r = a;
    c = 0;
    case (op)
      0, 1: begin
        c = (op == 1) ? int'(cy) : 0;
        v = ia + ib + c; r = v[7:0]; nc = (v > 255);
        na = ((ia % 16) + (ib % 16) + c) > 15; szp = 1'b1;
      end
      2, 3, 10: begin
        c = (op == 3) ? int'(cy) : 0;
        v = ia - ib - c; r = v[7:0]; nc = (v < 0);
        na = ((ia % 16) - (ib % 16) - c) < 0; szp = 1'b1; keep = (op == 10);
      end
      4: begin v = ia + 1; r = v[7:0]; na = (ia % 16) == 15; szp = 1'b1; end
      5: begin v = ia - 1; r = v[7:0]; na = (ia % 16) == 0; szp = 1'b1; end
      6: begin r = a & b; nc = 1'b0; na = 1'b1; szp = 1'b1; end
      7: begin r = a | b; nc = 1'b0; na = 1'b0; szp = 1'b1; end
      8: begin r = a ^ b; nc = 1'b0; na = 1'b0; szp = 1'b1; end
      9: r = ~a;
      11: begin r = {a[6:0], a[7]}; nc = a[7]; end
      12: begin r = {a[0], a[7:1]}; nc = a[0]; end
      13: begin r = {a[6:0], cy}; nc = a[7]; end
      14: begin r = {cy, a[7:1]}; nc = a[0]; end
      15: begin
        lo = ((ia % 16) > 9) || ac;
        v = ia + (lo ? 6 : 0);
        na = lo && ((ia % 16) + 6 > 15);
        if ((v / 16) > 9 || cy) begin v = v + 96; nc = 1'b1; end
        else nc = 1'b0;
        r = v[7:0]; szp = 1'b1;
      end
      16: nc = 1'b1;
      17: nc = ~cy;
      default: ;
    endcase
    fo = 8'h02;
    fo[7] = szp ? r[7] : f[7];
    fo[6] = szp ? (r == 8'h00) : f[6];
    fo[2] = szp ? ~^r : f[2];
    fo[4] = na;
    fo[0] = nc;
    return {keep ? a : r, fo};
  endfunction

  task automatic drive(input logic [4:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic [7:0] f);
    logic [15:0] m;
    exp_t e;
    @(posedge clk);
    #1;
    opCode = op; accIn = a; operand = b; flagsIn = f;
    m = model(op, a, b, f);
    e.acc = m[15:8]; e.flg = m[7:0]; e.tag = tagOf(op); e.due = cycleCnt + 1;
    expQ.push_back(e);
  endtask

  // monitor: results are due one edge after the drive (R2)
  always @(negedge clk) begin
    if (rst_n) begin
      while (expQ.size() > 0 && expQ[0].due <= cycleCnt) begin
        checkCnt++;
        if (accOut !== expQ[0].acc) begin
          failCnt++;
          $display("FAIL %s acc: actual %02h expected %02h", expQ[0].tag, accOut, expQ[0].acc);
        end
        checkCnt++;
        if (flagsOut !== expQ[0].flg) begin
          failCnt++;
          $display("FAIL %s R13 R2 flags: actual %02h expected %02h", expQ[0].tag, flagsOut, expQ[0].flg);
        end
        void'(expQ.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", checkCnt, failCnt);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checkCnt++; failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkCnt++;   // R1 reset values
    if (accOut !== 8'h00 || flagsOut !== 8'h02) begin
      failCnt++;
      $display("FAIL R1 reset: actual %02h/%02h expected 00/02", accOut, flagsOut);
    end
    rst_n = 1'b1;

    // R3
    drive(5'd0, 8'h3A, 8'h48, 8'h00);
    drive(5'd0, 8'hFF, 8'h01, 8'h00);
    drive(5'd0, 8'h80, 8'h80, 8'h01);
    drive(5'd1, 8'h7F, 8'h00, 8'h01);
    drive(5'd1, 8'hFF, 8'hFF, 8'h01);
    // R4
    drive(5'd2, 8'h10, 8'h01, 8'h01);
    drive(5'd2, 8'h05, 8'h05, 8'h00);
    drive(5'd2, 8'h00, 8'h01, 8'h00);
    drive(5'd3, 8'h00, 8'h00, 8'h01);
    drive(5'd3, 8'h50, 8'h20, 8'h00);
    // R5
    drive(5'd10, 8'h42, 8'h42, 8'h00);
    drive(5'd10, 8'h10, 8'h20, 8'h00);
    // R6
    drive(5'd4, 8'hFF, 8'h00, 8'h00);
    drive(5'd4, 8'h0F, 8'h00, 8'h01);
    drive(5'd5, 8'h00, 8'h00, 8'h00);
    drive(5'd5, 8'h01, 8'h00, 8'h01);
    // R7
    drive(5'd6, 8'hF0, 8'h3C, 8'h01);
    drive(5'd7, 8'h00, 8'h00, 8'h11);
    drive(5'd8, 8'hAA, 8'hAA, 8'h11);
    drive(5'd8, 8'h0F, 8'hF1, 8'h00);
    // R8
    drive(5'd9, 8'h5A, 8'h00, 8'hD7);
    // R9 and R10
    drive(5'd11, 8'h81, 8'h00, 8'h00);
    drive(5'd12, 8'h01, 8'h00, 8'h00);
    drive(5'd13, 8'h80, 8'h00, 8'h00);
    drive(5'd13, 8'h00, 8'h00, 8'h01);
    drive(5'd14, 8'h01, 8'h00, 8'h00);
    drive(5'd14, 8'h00, 8'h00, 8'h01);
    // R11
    drive(5'd15, 8'h9A, 8'h00, 8'h00);
    drive(5'd15, 8'h15, 8'h00, 8'h10);
    drive(5'd15, 8'h99, 8'h00, 8'h00);
    drive(5'd15, 8'h73, 8'h00, 8'h01);
    drive(5'd15, 8'h3C, 8'h00, 8'h00);
    drive(5'd15, 8'hFA, 8'h00, 8'h00);
    // R12
    drive(5'd16, 8'h12, 8'h00, 8'hC4);
    drive(5'd17, 8'h12, 8'h00, 8'h01);
    drive(5'd17, 8'h12, 8'h00, 8'h00);
    // R14 and R2 fixed bits with stray input bits
    drive(5'd20, 8'h77, 8'h11, 8'hFF);
    drive(5'd31, 8'h00, 8'h00, 8'h28);

    // sweep of every code with mixed data
    for (int op = 0; op < 18; op++) begin
      for (int k = 0; k < 4; k++) begin
        drive(5'(op), 8'(op * 37 + k * 91 + 11), 8'(op * 53 + k * 29 + 7), 8'(k * 85 + op));
      end
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    checkCnt++;
    if (expQ.size() != 0) begin
      failCnt++;
      $display("FAIL R2 pending results: actual %0d expected 0", expQ.size());
    end
    finish_run();
  end

endmodule